// File: doc/BRIEF.md
# Multiplexed ADC Scan Host

This block is the host end of a serial link to a 12-bit sampling converter that has two or four multiplexed inputs. It divides the system clock down to a serial clock, drives the active-low chip select, and shifts a channel-select word to the converter. It collects each 12-bit result and reports it with the index of the channel that produced it. The block steps through the channels in a fixed rotating order.

A conversion frame has 16 serial clocks. The first four clocks carry the select word, and the result arrives during the last twelve. The converter applies a select word to the conversion that follows, not to the frame that carries it. Each result therefore belongs to the channel sent one frame earlier. The first frame after a start has no meaningful channel, so its result is dropped. One serial-clock slot with no edge follows every frame.

In free-running mode, chip select stays asserted across that slot. In slave mode, chip select is raised during that slot, so every conversion starts on a fresh falling edge of chip select. The host releases its data line after the select word, so the serial data pin can share a wire with the converter's data output.

Top module: `adc_scan_host`

## Requirements
- R1: `sclk_o` has a period of CLK_DIV system clocks. Each period is low for CLK_DIV/2 clocks and then high. `sclk_o` is low while the block is idle.
- R2: Each frame has 16 rising edges of `sclk_o`, followed by one slot with no edge. Rising edges on either side of that slot are 2*CLK_DIV clocks apart.
- R3: During slots 0 to 3, the host drives a 4-bit select word on `din_o`, most significant bit first. The word holds the channel index in its low bits and zeros above. `din_oe_o` is high only in those four slots, and `din_o` does not change while `sclk_o` is high.
- R4: `dout_i` is sampled on the rising edges of slots 4 to 15. The first bit sampled becomes bit 11 of `res_data_o`.
- R5: `res_valid_o` pulses for one system clock in the cycle after the 16th rising edge of a frame. The first frame after each start produces no pulse.
- R6: `res_ch_o` carries the channel whose select word was sent in the frame before the reported one. The first tag after a start is 0.
- R7: Requested channels follow the order 0, 1, ..., NUM_CH-1 and then wrap to 0. Each start begins again at channel 0.
- R8: In free-running mode, `cs_n_o` stays low for as long as the block runs, including the slot with no edge.
- R9: In slave mode, `cs_n_o` is low for the 16 clocked slots and high for exactly one slot (CLK_DIV clocks) between frames. `sclk_o` is never high while `cs_n_o` is high. The mode is taken from `slave_mode_i` at the start of each frame.
- R10: If `enable_i` falls, the current frame still finishes and reports its result. The block then stops with `sclk_o` low, `cs_n_o` high and no further results. It also wakes from reset in this idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Run request; conversion starts when high and stops after the current frame when low |
| slave_mode_i | input | 1 | 1 = chip select pulses for each frame, 0 = free-running |
| dout_i | input | 1 | Serial result data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| din_o | output | 1 | Serial channel-select data to the converter |
| din_oe_o | output | 1 | Drive enable for `din_o`, for a shared data wire |
| res_valid_o | output | 1 | One-cycle strobe marking a new result |
| res_data_o | output | 12 | Result value, most significant bit first on the wire |
| res_ch_o | output | CH_W | Channel index of the result (1 bit for 2 channels, 2 bits for 4) |

## Verification
The assertions assume the converter changes `dout_i` only just after a falling edge of `sclk_o`, so the value is settled by the next rising edge. They also assume `enable_i` and `slave_mode_i` only matter at frame boundaries. The bench's converter model meets these assumptions by driving its data bit on each falling serial-clock edge. It captures the select bits on rising edges and applies them to the next conversion. All bench inputs change on falling system-clock edges. Enable is dropped partway through a frame, so the finish-then-stop path is exercised.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int unsigned FRAME_CLOCKS = 16;
    localparam int unsigned CFG_SLOTS    = 4;
    localparam int unsigned RESULT_BITS  = 12;
    localparam int unsigned SLOT_W       = 5;

    // Slot numbers inside one conversion (slot 16 is the edge-free slot)
    localparam logic [SLOT_W-1:0] SLOT_GAP        = SLOT_W'(FRAME_CLOCKS);
    localparam logic [SLOT_W-1:0] SLOT_CFG_END    = SLOT_W'(CFG_SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_DATA_FIRST = SLOT_W'(FRAME_CLOCKS - RESULT_BITS);
    localparam logic [SLOT_W-1:0] SLOT_DATA_LAST  = SLOT_W'(FRAME_CLOCKS - 1);

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Single-cycle strobes produced by the serial clock divider
    typedef struct packed {
        logic rise;
        logic slot_end;
    } sclk_evt_t;

    // Select-word bit for a config slot, highest bit in slot 0
    function automatic logic cfg_bit(input logic [CFG_SLOTS-1:0] word,
                                     input logic [1:0] slot_lo);
        logic [1:0] idx;
        idx = 2'(CFG_SLOTS - 1) - slot_lo;
        return word[idx];
    endfunction

    function automatic logic in_data_window(input logic [SLOT_W-1:0] slot);
        return (slot >= SLOT_DATA_FIRST) && (slot <= SLOT_DATA_LAST);
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen
    import adc_scan_pkg::*;
#(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      toggle_en,
    output logic      sclk,
    output sclk_evt_t evt
);

    localparam int unsigned PH_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int unsigned LOW_LEN = CLK_DIV / 2;
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(LOW_LEN - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);

    logic [PH_W-1:0] ph_q;
    logic            sclk_q;

    always_comb begin
        evt.rise     = run && toggle_en && (ph_q == PH_RISE);
        evt.slot_end = run && (ph_q == PH_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q <= '0;
        end else if (evt.slot_end) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sclk_q <= 1'b0;
        end else if (evt.rise) begin
            sclk_q <= 1'b1;
        end else if (evt.slot_end) begin
            sclk_q <= 1'b0;
        end
    end

    assign sclk = sclk_q;

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_scan_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              slave_mode_i,
    input  logic              slot_end,
    output logic              run,
    output logic [SLOT_W-1:0] slot,
    output logic              slave_q,
    output logic [CH_W-1:0]   cur_ch,
    output logic [CH_W-1:0]   prev_ch,
    output logic              first_q
);

    localparam logic [CH_W-1:0] CH_MAX = CH_W'(NUM_CH - 1);

    seq_state_e        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CH_W-1:0]   cur_q;
    logic [CH_W-1:0]   prev_q;
    logic              first_r;
    logic              slave_r;
    logic [CH_W-1:0]   nxt_ch;

    generate
        if ((1 << CH_W) == NUM_CH) begin : g_wrap_free
            assign nxt_ch = cur_q + 1'b1;
        end else begin : g_wrap_cmp
            assign nxt_ch = (cur_q == CH_MAX) ? '0 : cur_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            cur_q   <= '0;
            prev_q  <= '0;
            first_r <= 1'b1;
            slave_r <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (enable_i) begin
                        state_q <= SEQ_RUN;
                        slot_q  <= '0;
                        cur_q   <= '0;
                        first_r <= 1'b1;
                        slave_r <= slave_mode_i;
                    end
                end
                SEQ_RUN: begin
                    if (slot_end) begin
                        if (slot_q == SLOT_GAP) begin
                            prev_q  <= cur_q;
                            cur_q   <= nxt_ch;
                            first_r <= 1'b0;
                            slot_q  <= '0;
                            slave_r <= slave_mode_i;
                            if (!enable_i) begin
                                state_q <= SEQ_IDLE;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign run     = (state_q == SEQ_RUN);
    assign slot    = slot_q;
    assign slave_q = slave_r;
    assign cur_ch  = cur_q;
    assign prev_ch = prev_q;
    assign first_q = first_r;

endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture
    import adc_scan_pkg::*;
#(
    parameter int unsigned CH_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sample_en,
    input  logic                   last_en,
    input  logic                   keep,
    input  logic                   dout_i,
    input  logic [CH_W-1:0]        tag_i,
    output logic                   res_valid,
    output logic [RESULT_BITS-1:0] res_data,
    output logic [CH_W-1:0]        res_ch
);

    logic [RESULT_BITS-2:0] sh_q;
    logic                   valid_q;
    logic [RESULT_BITS-1:0] data_q;
    logic [CH_W-1:0]        ch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
            ch_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            if (sample_en) begin
                sh_q <= {sh_q[RESULT_BITS-3:0], dout_i};
            end
            if (last_en && keep) begin
                valid_q <= 1'b1;
                data_q  <= {sh_q, dout_i};
                ch_q    <= tag_i;
            end
        end
    end

    assign res_valid = valid_q;
    assign res_data  = data_q;
    assign res_ch    = ch_q;

endmodule

// File: rtl/adc_scan_host.sv
module adc_scan_host
    import adc_scan_pkg::*;
#(
    parameter  int unsigned CLK_DIV = 4,
    parameter  int unsigned NUM_CH  = 4,
    localparam int unsigned CH_W    = (NUM_CH > 2) ? 2 : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable_i,
    input  logic                   slave_mode_i,
    input  logic                   dout_i,
    output logic                   sclk_o,
    output logic                   cs_n_o,
    output logic                   din_o,
    output logic                   din_oe_o,
    output logic                   res_valid_o,
    output logic [RESULT_BITS-1:0] res_data_o,
    output logic [CH_W-1:0]        res_ch_o
);

    generate
        if (CLK_DIV < 2 || (NUM_CH != 2 && NUM_CH != 4)) begin : g_bad_cfg
            $error("adc_scan_host: CLK_DIV must be >= 2 and NUM_CH 2 or 4");
        end
    endgenerate

    logic              run;
    logic [SLOT_W-1:0] slot;
    logic              slave_q;
    logic [CH_W-1:0]   cur_ch;
    logic [CH_W-1:0]   prev_ch;
    logic              first_q;
    sclk_evt_t         evt;
    logic              clocked_slot;
    logic              cfg_slot;
    logic [CFG_SLOTS-1:0] cfg_word;

    assign clocked_slot = (slot < SLOT_GAP);
    assign cfg_slot     = run && (slot < SLOT_CFG_END);
    assign cfg_word     = CFG_SLOTS'(cur_ch);

    adc_sclk_gen #(
        .CLK_DIV (CLK_DIV)
    ) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .toggle_en (clocked_slot),
        .sclk      (sclk_o),
        .evt       (evt)
    );

    adc_frame_seq #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .enable_i     (enable_i),
        .slave_mode_i (slave_mode_i),
        .slot_end     (evt.slot_end),
        .run          (run),
        .slot         (slot),
        .slave_q      (slave_q),
        .cur_ch       (cur_ch),
        .prev_ch      (prev_ch),
        .first_q      (first_q)
    );

    adc_rx_capture #(
        .CH_W (CH_W)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .sample_en (evt.rise && in_data_window(slot)),
        .last_en   (evt.rise && (slot == SLOT_DATA_LAST)),
        .keep      (!first_q),
        .dout_i    (dout_i),
        .tag_i     (prev_ch),
        .res_valid (res_valid_o),
        .res_data  (res_data_o),
        .res_ch    (res_ch_o)
    );

    assign din_oe_o = cfg_slot;
    assign din_o    = cfg_slot ? cfg_bit(cfg_word, slot[1:0]) : 1'b0;
    assign cs_n_o   = !(run && !(slave_q && (slot == SLOT_GAP)));

endmodule

// File: rtl/adc_scan_host_sva.sv
module adc_scan_host_sva #(
    parameter  int unsigned CLK_DIV = 4,
    parameter  int unsigned NUM_CH  = 4,
    localparam int unsigned CH_W    = (NUM_CH > 2) ? 2 : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            run_i,
    input logic            sclk_o,
    input logic            cs_n_o,
    input logic            din_o,
    input logic            din_oe_o,
    input logic            res_valid_o,
    input logic [CH_W-1:0] res_ch_o
);

    logic            sclk_d;
    logic [15:0]     gap_q;
    logic            gap_seen_q;
    logic [CH_W-1:0] last_ch_q;
    logic            have_ch_q;
    logic [CH_W-1:0] exp_ch;

    assign exp_ch = (last_ch_q == CH_W'(NUM_CH - 1)) ? '0 : last_ch_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d     <= 1'b0;
            gap_q      <= '0;
            gap_seen_q <= 1'b0;
            last_ch_q  <= '0;
            have_ch_q  <= 1'b0;
        end else begin
            sclk_d <= sclk_o;
            if (!run_i) begin
                gap_q      <= '0;
                gap_seen_q <= 1'b0;
            end else if (sclk_o && !sclk_d) begin
                gap_q      <= 16'd1;
                gap_seen_q <= 1'b1;
            end else if (gap_q != 16'hFFFF) begin
                gap_q <= gap_q + 16'd1;
            end
            if (!run_i) begin
                have_ch_q <= 1'b0;
            end else if (res_valid_o) begin
                have_ch_q <= 1'b1;
                last_ch_q <= res_ch_o;
            end
        end
    end

    p_sclk_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> !sclk_o);

    p_cs_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> cs_n_o);

    p_sclk_under_cs_r9: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !cs_n_o);

    p_din_steady_high_r3: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && sclk_d) |-> $stable(din_o));

    p_oe_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        din_oe_o |-> !cs_n_o);

    p_rise_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && !sclk_d && gap_seen_q) |->
            (gap_q == 16'(CLK_DIV) || gap_q == 16'(2 * CLK_DIV)));

    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    p_valid_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (sclk_o && !sclk_d));

    p_first_tag_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !have_ch_q) |-> (res_ch_o == '0));

    p_rr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && have_ch_q) |-> (res_ch_o == exp_ch));

endmodule

bind adc_scan_host adc_scan_host_sva #(
    .CLK_DIV (CLK_DIV),
    .NUM_CH  (NUM_CH)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run),
    .sclk_o      (sclk_o),
    .cs_n_o      (cs_n_o),
    .din_o       (din_o),
    .din_oe_o    (din_oe_o),
    .res_valid_o (res_valid_o),
    .res_ch_o    (res_ch_o)
);

// File: tb/adc_scan_host_test.sv
`timescale 1ns/1ps
module adc_scan_host_test;

    localparam int unsigned CLK_DIV = 4;
    localparam int unsigned NUM_CH  = 4;
    localparam real         PER     = 5.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        slave = 1'b0;
    logic        dout = 1'b0;
    logic        sclk, cs_n, din, din_oe, res_valid;
    logic [11:0] res_data;
    logic [1:0]  res_ch;

    adc_scan_host #(.CLK_DIV(CLK_DIV), .NUM_CH(NUM_CH)) uut (
        .clk(clk), .rst(rst), .enable_i(enable), .slave_mode_i(slave),
        .dout_i(dout), .sclk_o(sclk), .cs_n_o(cs_n), .din_o(din),
        .din_oe_o(din_oe), .res_valid_o(res_valid), .res_data_o(res_data),
        .res_ch_o(res_ch)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter model state
    int          rc = 0;
    logic [3:0]  cfg = '0;
    int          conv_ch = 3;
    int          fidx = 0;
    logic [11:0] last_sample = '0;
    int          last_ch = 0;
    int          exp_req = 0;
    realtime     t_rise = 0.0;
    realtime     t_cs_up = 0.0;
    bit          rise_seen = 0;
    bit          cs_chk = 0;
    bit          free_chk = 0;
    int          frames = 0;
    int          valids = 0;

    function automatic logic [11:0] sample_of(input int ch, input int f);
        return 12'h5A3 ^ {2'(ch), 10'(f)};
    endfunction

    always @(posedge sclk) begin : conv_rise
        realtime d, e;
        chk(din_oe == (rc < 4), "R3", "din_oe at rising edge", int'(din_oe), int'(rc < 4));
        if (rise_seen) begin
            d = $realtime - t_rise;
            e = (rc == 0) ? 2.0 * CLK_DIV * PER : CLK_DIV * PER;
            chk((d - e < 0.1) && (e - d < 0.1), (rc == 0) ? "R2" : "R1",
                "rise spacing x10ns", $rtoi(d * 10.0), $rtoi(e * 10.0));
        end
        rise_seen = 1;
        t_rise = $realtime;
        if (rc < 4) cfg = {cfg[2:0], din};
        rc++;
        if (rc == 16) begin
            chk(cfg == 4'(exp_req), "R7", "select word (R3 upper bits zero)", int'(cfg), exp_req);
            exp_req = (exp_req + 1) % NUM_CH;
            last_sample = sample_of(conv_ch, fidx);
            last_ch = conv_ch;
            conv_ch = int'(cfg[1:0]);
            fidx++;
            frames++;
            rc = 0;
        end
    end

    always @(negedge sclk) begin : conv_fall
        logic [11:0] s;
        s = sample_of(conv_ch, fidx);
        if (rc >= 4 && rc <= 15) dout = s[15 - rc];
        else dout = 1'b0;
    end

    always @(posedge cs_n) begin
        rc = 0;
        t_cs_up = $realtime;
        if (free_chk) chk(1'b0, "R8", "chip select rose in free-running mode", 1, 0);
    end

    always @(negedge cs_n) begin : cs_width
        realtime w;
        w = $realtime - t_cs_up;
        if (cs_chk)
            chk((w - CLK_DIV * PER < 0.1) && (CLK_DIV * PER - w < 0.1), "R9",
                "chip select high width x10ns", $rtoi(w * 10.0), $rtoi(CLK_DIV * PER * 10.0));
    end

    always @(negedge clk) begin
        if (res_valid) begin
            valids++;
            chk(res_data == last_sample, "R4", "result data", int'(res_data), int'(last_sample));
            chk(int'(res_ch) == last_ch, "R6", "result channel tag", int'(res_ch), last_ch);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual %0d expected below %0d cycles", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic t_reset();
        chk(sclk == 1'b0, "R10", "sclk after reset", int'(sclk), 0);
        chk(cs_n == 1'b1, "R10", "cs_n after reset", int'(cs_n), 1);
        chk(res_valid == 1'b0, "R10", "valid after reset", int'(res_valid), 0);
        chk(din_oe == 1'b0, "R3", "din_oe after reset", int'(din_oe), 0);
        repeat (3 * CLK_DIV) @(negedge clk);
        chk(sclk == 1'b0, "R1", "sclk idle while disabled", int'(sclk), 0);
    endtask

    task automatic run_mode(input bit slave_mode, input int n_valid);
        int fr;
        int vs;
        exp_req = 0;
        rise_seen = 0;
        frames = 0;
        valids = 0;
        slave = slave_mode;
        enable = 1'b1;
        @(negedge cs_n);
        @(negedge clk);
        if (slave_mode) cs_chk = 1; else free_chk = 1;
        while (valids < n_valid) @(negedge clk);
        chk(frames == n_valid + 1, "R5", "first frame discarded", valids, frames - 1);
        repeat (5 * CLK_DIV) @(negedge clk);
        cs_chk = 0;
        free_chk = 0;
        enable = 1'b0;
        fr = frames;
        repeat (20 * CLK_DIV) @(negedge clk);
        chk(frames == fr + 1, "R10", "frame finished after disable", frames, fr + 1);
        chk(valids == frames - 1, "R5", "results per run", valids, frames - 1);
        chk(sclk == 1'b0, "R10", "sclk after stop", int'(sclk), 0);
        chk(cs_n == 1'b1, "R10", "cs_n after stop", int'(cs_n), 1);
        vs = valids;
        repeat (40) @(negedge clk);
        chk(valids == vs, "R10", "no results while stopped", valids, vs);
    endtask

    task automatic t_free_run();
        run_mode(1'b0, 6);
    endtask

    task automatic t_slave_run();
        run_mode(1'b1, 5);
    endtask

    task automatic t_restart();
        run_mode(1'b0, 2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_free_run();
        t_slave_run();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule